// File: doc/BRIEF.md
# Serial Command Port with Frame-Length Check

This block is the serial command port of a six-channel low-side driver controller. A host selects it with an active-low chip select, then clocks 16-bit words through it, most significant bit first. Command bits come in on the serial input, and fault bits go out on the serial output at the same time. The serial clock, chip select and data input are oversampled by a faster system clock through two-flop synchronizers. All edge detection happens in the system clock domain.

When chip select is released, the port checks that the number of serial clocks was a nonzero multiple of 16. Only then does it decode the final 16 received bits into a write to one of four 6-bit control registers: gate select, disable mode, refresh/reference and flag mask. Longer frames that are still a multiple of 16 let the port sit in a daisy chain, because after the first 16 clocks the output repeats the bits received earlier in the frame.

The block also keeps a latched 12-bit fault word (two bits per channel, channel 5 highest) and an active-low fault flag. Selecting the port disarms the flag and hands the latched word to the output shifter. A valid frame end replaces the latched word with the faults present at that moment and arms the flag again. While the port is deselected, further faults are added to the latched word.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset all four control registers read 0, `so_oe` is 0 and, with no fault input active, `fault_n` is 1.
- R2: While chip select is low, `so_oe` is 1 and `so` presents the 16-bit word {4'b0000, latched faults}, MSB first. The first bit is shown before the first serial clock, and `so` moves to the next bit after each falling serial clock edge. `so_oe` is 0 while chip select is high.
- R3: A frame of exactly 16 clocks whose received bits 15:14 are 00 writes received bits 5:0 into the register picked by bits 13:12: 00 gate select, 01 disable mode, 10 refresh/reference, 11 flag mask. No other register changes.
- R4: In a frame of 32 or 48 clocks only the last 16 received bits are decoded. From clock 17 on, `so` repeats the received stream, starting with the first bit received.
- R5: A frame whose clock count is zero or not a multiple of 16 changes no register. The latched fault word it leaves behind is the one read out in the next frame.
- R6: A valid frame whose received bit 15 or bit 14 is 1 is a null command and changes no register.
- R7: While chip select is low, `fault_n` is 1 whatever the faults are.
- R8: At the end of a valid frame the latched word becomes the current fault input and the flag is armed, so `fault_n` is 0 exactly when that word is nonzero.
- R9: After a rejected frame the flag stays disarmed (`fault_n` = 1) until the next valid frame ends.
- R10: Faults present only while chip select is low are never latched. Faults present while it is high are added to the latched word and stay until the next valid frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| csb_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial command data in |
| fault_in | input | 12 | Current fault bits, two per channel, channel 5 in bits 11:10 |
| so | output | 1 | Serial fault data out |
| so_oe | output | 1 | Output enable for `so` (1 = driven, 0 = high impedance) |
| fault_n | output | 1 | Active-low fault flag |
| gate_sel | output | 6 | Gate select register |
| dis_mode | output | 6 | Disable mode register |
| refresh_ref | output | 6 | Refresh and reference register |
| flag_mask | output | 6 | Flag mask register |

## Verification
Assertions run on every cycle and cover these checks:
- Rejected frames and null commands leave the register file untouched.
- A valid write lands in the gate select register.
- The output enable drops when chip select is released.
- The flag is disarmed on selection.
- The latched fault word stays frozen while the port is selected and takes the fault input on a valid frame end.

Only the bench scenarios can show the rest:
- the serial bit order on `so` and the daisy-chain repetition;
- that only the last 16 bits of a long frame are decoded;
- that a rejected frame's fault word reappears in the next readout;
- that a fault pulse seen only during selection is lost.

// File: rtl/spi_cmd_pkg.sv
// Shared constants for the serial command port.
// Assumes one fixed word size and four control registers at addresses 0..3.
package spi_cmd_pkg;
    localparam int WORD_BITS  = 16;
    localparam int CHANNELS   = 6;
    localparam int REG_BITS   = 6;
    localparam int NUM_REGS   = 4;
    localparam int HDR_BITS   = 4;

    typedef enum logic [1:0] {
        SEL_GATE    = 2'd0,
        SEL_DISABLE = 2'd1,
        SEL_REFRESH = 2'd2,
        SEL_MASK    = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/spi_pin_sync.sv
// Two-flop synchronizer for a group of slow pins, plus one extra stage so
// that the caller can find edges. Assumes each pin holds for at least
// three system clocks between changes.
module spi_pin_sync #(
    parameter int         W    = 2,
    parameter logic [W-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);
    logic [W-1:0] s1, s2, s3;

    // Shift the pin values through the synchronizer and edge stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= IDLE;
            s2 <= IDLE;
            s3 <= IDLE;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign lvl  = s2;
    assign prev = s3;
endmodule

// File: rtl/spi_frame_unit.sv
// Serial shifter and frame-length checker.
// Shifts data in on rising serial clock edges and out on falling edges, and
// counts clocks modulo the word size. frame_ok is high while the count is a
// nonzero multiple of the word size. Assumes edge strobes are one system
// clock wide and that chip-select edges never coincide with clock edges.
module spi_frame_unit #(
    parameter int WORD_BITS = 16,
    parameter int HDR_BITS  = 4,
    parameter int REG_BITS  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 si,
    input  logic                 csb_low,
    input  logic                 csb_fall,
    input  logic                 csb_rise,
    input  logic                 sclk_rise,
    input  logic                 sclk_fall,
    input  logic [WORD_BITS-1:0] tx_load,
    output logic                 so,
    output logic                 so_oe,
    output logic                 frame_ok,
    output logic [HDR_BITS-1:0]  cmd_hdr,
    output logic [REG_BITS-1:0]  cmd_data
);
    localparam int CNT_W = $clog2(WORD_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

    logic                 si_s1, si_s2;
    logic [CNT_W-1:0]     bit_cnt;
    logic                 got_bits;
    logic [WORD_BITS-1:0] rx_sr;
    logic [WORD_BITS-1:0] tx_sr;

    // Bring the data pin into the system clock with the same delay as sclk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            si_s1 <= 1'b0;
            si_s2 <= 1'b0;
        end else begin
            si_s1 <= si;
            si_s2 <= si_s1;
        end
    end

    // Count serial clocks modulo the word size during a selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            got_bits <= 1'b0;
        end else if (csb_fall) begin
            bit_cnt  <= '0;
            got_bits <= 1'b0;
        end else if (sclk_rise && csb_low) begin
            bit_cnt  <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
            got_bits <= 1'b1;
        end
    end

    // Receive shifter, MSB first, on rising serial clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (sclk_rise && csb_low) begin
            rx_sr <= {rx_sr[WORD_BITS-2:0], si_s2};
        end
    end

    // Transmit shifter: load on selection, advance on falling edges, refill
    // from received bits so that long frames pass data along a chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
            so_oe <= 1'b0;
        end else if (csb_fall) begin
            tx_sr <= tx_load;
            so_oe <= 1'b1;
        end else if (csb_rise) begin
            so_oe <= 1'b0;
        end else if (sclk_fall && csb_low) begin
            tx_sr <= {tx_sr[WORD_BITS-2:0], rx_sr[0]};
        end
    end

    assign so       = tx_sr[WORD_BITS-1];
    assign frame_ok = got_bits && (bit_cnt == '0);
    assign cmd_hdr  = rx_sr[WORD_BITS-1 -: HDR_BITS];
    assign cmd_data = rx_sr[REG_BITS-1:0];

    // R2
    so_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csb_rise |=> !so_oe);
    // R2
    so_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csb_fall |=> (so_oe && so == $past(tx_load[WORD_BITS-1])));
endmodule

// File: rtl/spi_reg_bank.sv
// Four control registers written by decoded frames.
// A write lands only at a valid frame end, when the header's upper bits are
// zero. The low header bits select the register. Assumes NUM_REGS is a
// power of two that fits inside the header.
module spi_reg_bank #(
    parameter int HDR_BITS = 4,
    parameter int REG_BITS = 6,
    parameter int NUM_REGS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         csb_rise,
    input  logic                         frame_ok,
    input  logic [HDR_BITS-1:0]          cmd_hdr,
    input  logic [REG_BITS-1:0]          cmd_data,
    output logic [NUM_REGS*REG_BITS-1:0] regs_flat
);
    localparam int SEL_W = $clog2(NUM_REGS);

    logic             commit;
    logic             null_cmd;
    logic [SEL_W-1:0] sel;

    assign commit   = csb_rise && frame_ok;
    assign null_cmd = |cmd_hdr[HDR_BITS-1:SEL_W];
    assign sel      = cmd_hdr[SEL_W-1:0];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Update register g when a non-null frame addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_flat[g*REG_BITS +: REG_BITS] <= '0;
            end else if (commit && !null_cmd && sel == SEL_W'(g)) begin
                regs_flat[g*REG_BITS +: REG_BITS] <= cmd_data;
            end
        end
    end

    // R5
    reject_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csb_rise && !frame_ok) |=> $stable(regs_flat));
    // R6
    null_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cmd_hdr[HDR_BITS-1]) |=> $stable(regs_flat));
    // R3
    gate_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cmd_hdr == '0) |=> regs_flat[REG_BITS-1:0] == $past(cmd_data));
endmodule

// File: rtl/spi_fault_unit.sv
// Fault word latch and active-low fault flag.
// While deselected, the latch adds current faults to the word. A valid frame
// end replaces it with the current faults and arms the flag. Selection
// disarms the flag. Assumes fault_in is already in the system clock domain.
module spi_fault_unit #(
    parameter int FAULT_BITS = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  csb_high,
    input  logic                  csb_fall,
    input  logic                  commit,
    input  logic [FAULT_BITS-1:0] fault_in,
    output logic [FAULT_BITS-1:0] latched,
    output logic                  fault_n
);
    logic flag_en;

    // Arm the flag at reset and at valid frame ends; disarm on selection.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_en <= 1'b1;
        else if (csb_fall) flag_en <= 1'b0;
        else if (commit)   flag_en <= 1'b1;
    end

    // Replace the word on commit; otherwise add faults while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)        latched <= '0;
        else if (commit)   latched <= fault_in;
        else if (csb_high) latched <= latched | fault_in;
    end

    assign fault_n = !(flag_en && (|latched));

    // R8
    capture_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> latched == $past(fault_in));
    // R7
    flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csb_fall |=> fault_n);
    // R10
    frozen_while_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!csb_high && !commit) |=> $stable(latched));
endmodule

// File: rtl/spi_cmd_slave.sv
// Top of the serial command port. It synchronizes the serial pins, finds
// their edges, and connects the frame unit, register bank and fault unit.
// Assumes the serial clock half period is at least four system clocks.
module spi_cmd_slave
    import spi_cmd_pkg::*;
#(
    parameter int FRAME_BITS = WORD_BITS,
    parameter int NUM_CH     = CHANNELS,
    parameter int DATA_BITS  = REG_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  csb_n,
    input  logic                  si,
    input  logic [2*NUM_CH-1:0]   fault_in,
    output logic                  so,
    output logic                  so_oe,
    output logic                  fault_n,
    output logic [DATA_BITS-1:0]  gate_sel,
    output logic [DATA_BITS-1:0]  dis_mode,
    output logic [DATA_BITS-1:0]  refresh_ref,
    output logic [DATA_BITS-1:0]  flag_mask
);
    localparam int FAULT_BITS = 2 * NUM_CH;
    localparam int PAD_BITS   = FRAME_BITS - FAULT_BITS;

    logic [1:0]                    pin_lvl, pin_prev;
    logic                          csb_lvl, csb_fall, csb_rise;
    logic                          sclk_rise, sclk_fall;
    logic                          frame_ok, commit;
    logic [HDR_BITS-1:0]           cmd_hdr;
    logic [DATA_BITS-1:0]          cmd_data;
    logic [FAULT_BITS-1:0]         latched;
    logic [NUM_REGS*DATA_BITS-1:0] regs_flat;

    spi_pin_sync #(.W(2), .IDLE(2'b10)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   ({csb_n, sclk}),
        .lvl   (pin_lvl),
        .prev  (pin_prev)
    );

    assign csb_lvl   = pin_lvl[1];
    assign csb_fall  = !pin_lvl[1] &&  pin_prev[1];
    assign csb_rise  =  pin_lvl[1] && !pin_prev[1];
    assign sclk_rise =  pin_lvl[0] && !pin_prev[0];
    assign sclk_fall = !pin_lvl[0] &&  pin_prev[0];
    assign commit    = csb_rise && frame_ok;

    spi_frame_unit #(
        .WORD_BITS (FRAME_BITS),
        .HDR_BITS  (HDR_BITS),
        .REG_BITS  (DATA_BITS)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .si        (si),
        .csb_low   (!csb_lvl),
        .csb_fall  (csb_fall),
        .csb_rise  (csb_rise),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .tx_load   ({{PAD_BITS{1'b0}}, latched}),
        .so        (so),
        .so_oe     (so_oe),
        .frame_ok  (frame_ok),
        .cmd_hdr   (cmd_hdr),
        .cmd_data  (cmd_data)
    );

    spi_reg_bank #(
        .HDR_BITS (HDR_BITS),
        .REG_BITS (DATA_BITS),
        .NUM_REGS (NUM_REGS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .csb_rise  (csb_rise),
        .frame_ok  (frame_ok),
        .cmd_hdr   (cmd_hdr),
        .cmd_data  (cmd_data),
        .regs_flat (regs_flat)
    );

    spi_fault_unit #(.FAULT_BITS(FAULT_BITS)) u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .csb_high (csb_lvl),
        .csb_fall (csb_fall),
        .commit   (commit),
        .fault_in (fault_in),
        .latched  (latched),
        .fault_n  (fault_n)
    );

    assign gate_sel    = regs_flat[SEL_GATE*DATA_BITS    +: DATA_BITS];
    assign dis_mode    = regs_flat[SEL_DISABLE*DATA_BITS +: DATA_BITS];
    assign refresh_ref = regs_flat[SEL_REFRESH*DATA_BITS +: DATA_BITS];
    assign flag_mask   = regs_flat[SEL_MASK*DATA_BITS    +: DATA_BITS];

    // R9
    reject_no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csb_rise && !frame_ok) |=> fault_n);
endmodule

// File: tb/spi_cmd_slave_test.sv
`timescale 1ns/1ps
module spi_cmd_slave_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        csb_n = 1'b1;
    logic        si = 1'b0;
    logic [11:0] fault_in = '0;
    logic        so, so_oe, fault_n;
    logic [5:0]  gate_sel, dis_mode, refresh_ref, flag_mask;

    int checks = 0;
    int errors = 0;
    logic [5:0]  exp_reg [4];
    logic [11:0] exp_lat;
    logic        exp_en;

    always #2.5 clk = ~clk;

    spi_cmd_slave uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .csb_n(csb_n), .si(si),
        .fault_in(fault_in), .so(so), .so_oe(so_oe), .fault_n(fault_n),
        .gate_sel(gate_sel), .dis_mode(dis_mode),
        .refresh_ref(refresh_ref), .flag_mask(flag_mask)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [23:0] regs_now();
        return {flag_mask, refresh_ref, dis_mode, gate_sel};
    endfunction

    function automatic logic [23:0] regs_exp();
        return {exp_reg[3], exp_reg[2], exp_reg[1], exp_reg[0]};
    endfunction

    function automatic bit frame_valid(input int n);
        return (n > 0) && (n % 16 == 0);
    endfunction

    // Drive one selection of n clocks; stream bit n-1 goes first.
    task automatic run_frame(input int n, input logic [63:0] stream,
                             input bit glitch, input logic [11:0] gval);
        logic [15:0] first;
        logic [11:0] saved;
        int bad_head = 0;
        int bad_tail = 0;
        string tag;
        first = {4'b0000, exp_lat};
        saved = fault_in;
        csb_n = 1'b0;
        idle(8);
        // R7 flag disarmed while selected
        check(fault_n == 1'b1, "R7 flag while selected", 64'(fault_n), 64'd1);
        // R2 output enabled while selected
        check(so_oe == 1'b1, "R2 so_oe while selected", 64'(so_oe), 64'd1);
        for (int i = 0; i < n; i++) begin
            si = stream[n-1-i];
            if (glitch && i == n/2) fault_in = gval;
            idle(8);
            if (i < 16) begin
                if (so !== first[15-i]) bad_head++;
            end else begin
                if (so !== stream[n-1-(i-16)]) bad_tail++;
            end
            sclk = 1'b1;
            idle(8);
            sclk = 1'b0;
        end
        fault_in = saved;
        idle(8);
        csb_n = 1'b1;
        idle(12);
        // R2 fault word shifted out MSB first
        check(bad_head == 0, "R2 fault word on so", 64'(bad_head), 64'd0);
        // R4 daisy-chain repetition
        if (n > 16) check(bad_tail == 0, "R4 so repeats input", 64'(bad_tail), 64'd0);
        // R2 output released
        check(so_oe == 1'b0, "R2 so_oe after release", 64'(so_oe), 64'd0);
        if (frame_valid(n)) begin
            if (stream[15:14] == 2'b00) exp_reg[stream[13:12]] = stream[5:0];
            exp_lat = fault_in;
            exp_en  = 1'b1;
            if (n > 16) tag = "R4 last word decoded";
            else if (stream[15:14] != 2'b00) tag = "R6 null command";
            else tag = "R3 register write";
        end else begin
            exp_lat = exp_lat | fault_in;
            exp_en  = 1'b0;
            tag = "R5 rejected frame";
        end
        check(regs_now() == regs_exp(), tag, 64'(regs_now()), 64'(regs_exp()));
        // R8 armed after valid end / R9 disarmed after rejection
        check(fault_n == !(exp_en && |exp_lat),
              frame_valid(n) ? "R8 flag after valid" : "R9 flag after reject",
              64'(fault_n), 64'(!(exp_en && |exp_lat)));
    endtask

    // Raise faults while deselected and confirm accumulation (R10).
    task automatic new_faults(input logic [11:0] f);
        fault_in = f;
        idle(6);
        exp_lat = exp_lat | f;
        check(fault_n == !(exp_en && |exp_lat), "R10 faults while deselected",
              64'(fault_n), 64'(!(exp_en && |exp_lat)));
    endtask

    function automatic logic [15:0] make_word();
        logic [3:0] hdr;
        int pick = $urandom_range(0, 9);
        hdr = {2'b00, 2'($urandom_range(0, 3))};
        if (pick == 0) hdr[3] = 1'b1;
        if (pick == 1) hdr[2] = 1'b1;
        return {hdr, 6'($urandom), 6'($urandom)};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lens [9] = '{16, 16, 32, 48, 0, 8, 15, 17, 31};
        logic [63:0] st;
        void'($urandom(32'h5EED));
        for (int k = 0; k < 4; k++) exp_reg[k] = '0;
        exp_lat = '0;
        exp_en  = 1'b1;
        idle(5);
        rst_n = 1'b1;
        idle(5);
        // R1 reset state
        check(regs_now() == 24'd0, "R1 registers after reset", 64'(regs_now()), 64'd0);
        check(so_oe == 1'b0, "R1 so_oe after reset", 64'(so_oe), 64'd0);
        check(fault_n == 1'b1, "R1 flag after reset", 64'(fault_n), 64'd1);

        // Directed: write gate select, then the flag mask, each exactly 16 clocks (R3)
        run_frame(16, 64'h002A, 1'b0, '0);
        run_frame(16, 64'h3015, 1'b0, '0);
        // Directed: latched fault readout, then a rejected frame keeping it (R5)
        new_faults(12'hA05);
        run_frame(17, 64'h1_103F, 1'b0, '0);
        run_frame(16, 64'h0000, 1'b0, '0);
        // Directed: fault pulse only while selected is lost (R10)
        fault_in = '0;
        idle(4);
        run_frame(16, 64'h1001, 1'b0, '0);
        run_frame(16, 64'h2002, 1'b1, 12'hFFF);
        run_frame(16, 64'h2003, 1'b0, '0);
        // Directed: 48-clock frame, only last word counts (R4)
        run_frame(48, {16'h0, 16'h003F, 16'h1FFF, 16'h1011}, 1'b0, '0);
        // Directed: null commands (R6)
        run_frame(16, 64'h8FFF, 1'b0, '0);
        run_frame(16, 64'h4FFF, 1'b0, '0);

        // Random mix of lengths, words and faults
        for (int t = 0; t < 40; t++) begin
            int n = lens[$urandom_range(0, 8)];
            st = {$urandom(), $urandom()};
            st[15:0] = make_word();
            run_frame(n, st, ($urandom_range(0, 3) == 0), 12'($urandom()));
            new_faults(($urandom_range(0, 2) == 0) ? 12'($urandom()) : 12'h000);
        end
        run_frame(16, 64'h0000, 1'b0, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule